// File: doc/BRIEF.md
# Configuration Address/Data Access Port

This block lets a host processor reach the configuration space of devices on an attached expansion bus through two registers on a simple 32-bit register bus. Software first writes an address register that selects a target bus, device, function and dword register index, and sets an enable bit. It then reads or writes a data register. For each data access that is allowed, the block issues one formatted configuration request on its downstream side and waits for that request to finish. Byte and halfword data accesses select byte lanes from a two-bit byte offset.

Before any request leaves the block, a filter checks the target against two pieces of state. The first is a local bus register, which holds the local bus number and device number. The second is a mode register with a card-slot bit, which narrows the devices that may be reached on the local bus. A blocked read returns all ones with a not-found status, and a blocked write is discarded. While a request is in flight the port is busy. Every host request made in that window is dropped, so the address/data pair behaves as one atomic sequence.

Top module: `cfgp_port`

## Requirements
- R1: A write to register select 0 (address) stores only the enable bit 31, bus 23:16, device 15:11, function 9:8 and register index 7:2. Every other bit reads back as zero.
- R2: An allowed data access (select 1, enable set, valid size) raises `cfg_req_valid` for exactly one cycle, in the cycle after the request. `cfg_req_addr` is then {8'h00, bus, device, 1'b0, function, index, 2'b00}, and `busy` rises in the same cycle.
- R3: A read completion returns the target dword shifted right by 8 × offset. The result is then masked to 8 bits for size 1, 16 bits for size 2, or left whole for size 4.
- R4: A data write drives `cfg_req_wdata` as the host data shifted left by 8 × offset. `cfg_req_be` has the lowest `size` lanes set and is shifted left by the offset, keeping the low 4 bits. A read drives `cfg_req_be` = 4'b1111.
- R5: Register select 2 (local bus) stores the local bus number in bits 23:16 and the local device number in bits 28:24. Both reset to zero. On the local bus, a data access to device 0 with a nonzero function is blocked.
- R6: Register select 3 bit 0 enables card-slot mode. In that mode, any data access on the local bus to a device above 1 is blocked. Accesses to other buses are not affected.
- R7: A blocked data access, or one made with the enable bit clear, issues no request. It responds in the next cycle with status 1 (not found) and read data 0xFFFFFFFF, and a write is discarded.
- R8: A data access with a size other than 1, 2 or 4 issues no request. It responds in the next cycle with status 2 (bad size) and data 0xFFFFFFFF.
- R9: `busy` stays high from the request until the cycle after `cfg_done`, when the block responds with status 0. While `busy` is high, host requests get no response and change no register.
- R10: After reset, all registers read as zero, and `busy`, `hb_rsp_valid` and `cfg_req_valid` are low.
- R11: An access to select 0, 2 or 3 responds in the next cycle with status 0. A read returns the stored value and a write returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hb_valid | input | 1 | Host request strobe |
| hb_write | input | 1 | 1 = write, 0 = read |
| hb_sel | input | 2 | Register select: 0 address, 1 data, 2 local bus, 3 mode |
| hb_off | input | 2 | Byte offset within the data dword |
| hb_size | input | 3 | Access size in bytes |
| hb_wdata | input | 32 | Host write data |
| hb_rsp_valid | output | 1 | Response strobe |
| hb_rsp_status | output | 2 | 0 ok, 1 not found, 2 bad size |
| hb_rsp_rdata | output | 32 | Response data |
| busy | output | 1 | A configuration request is in flight |
| cfg_req_valid | output | 1 | Configuration request pulse |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_addr | output | 32 | Formatted configuration address |
| cfg_req_be | output | 4 | Byte-lane enables |
| cfg_req_wdata | output | 32 | Lane-aligned write data |
| cfg_done | input | 1 | Target completion strobe |
| cfg_rdata | input | 32 | Target read data |

## Verification
Random data accesses spread targets across the local bus and a foreign bus. Device numbers are drawn from 0 to 3 and also at random, and functions, offsets and sizes are random. This tells the local-device-0 rule apart from the card-slot rule, and shows that neither rule leaks onto other buses. Directed cases cover:
- a clear enable bit;
- an illegal size;
- a halfword at offset 3, where only one lane remains;
- an address write issued while busy.

The last case separates a dropped request from one that was accepted.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam int DATA_W  = 32;
   localparam int EN_BIT  = 31;
   localparam int BUS_LSB = 16;
   localparam int DEV_LSB = 11;
   localparam int FN_LSB  = 8;
   localparam int REG_LSB = 2;
   localparam int LDEV_LSB = 24;

   typedef enum logic [1:0] {
      ST_OK        = 2'd0,
      ST_NOT_FOUND = 2'd1,
      ST_BAD_SIZE  = 2'd2,
      ST_RSVD      = 2'd3
   } cfgp_status_e;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_PEER = 2'd2,
      SEL_MODE = 2'd3
   } cfgp_sel_e;

   function automatic logic [DATA_W-1:0] fmask(input int lsb, input int w);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/cfgp_regs.sv
module cfgp_regs
   import cfgp_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int DEV_W = 5,
   parameter int FN_W  = 2,
   parameter int REG_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] peer_q,
   output logic              card_q,
   output logic [DATA_W-1:0] rd_val
);
   localparam logic [DATA_W-1:0] ADDR_MASK = fmask(EN_BIT, 1) | fmask(BUS_LSB, BUS_W) |
                                             fmask(DEV_LSB, DEV_W) | fmask(FN_LSB, FN_W) |
                                             fmask(REG_LSB, REG_W);
   localparam logic [DATA_W-1:0] PEER_MASK = fmask(BUS_LSB, BUS_W) | fmask(LDEV_LSB, DEV_W);

   if (BUS_LSB + BUS_W > LDEV_LSB) begin : g_bad_bus
      $error("bus field overlaps local device field");
   end
   if (LDEV_LSB + DEV_W > EN_BIT) begin : g_bad_ldev
      $error("local device field overlaps enable bit");
   end
   if (FN_LSB + FN_W > DEV_LSB || DEV_LSB + DEV_W > BUS_LSB || REG_LSB + REG_W > FN_LSB) begin : g_bad_fld
      $error("address fields overlap");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         peer_q <= '0;
         card_q <= 1'b0;
      end else if (wr_en) begin
         case (sel)
            SEL_ADDR: addr_q <= wdata & ADDR_MASK;
            SEL_PEER: peer_q <= wdata & PEER_MASK;
            SEL_MODE: card_q <= wdata[0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_ADDR: rd_val = addr_q;
         SEL_PEER: rd_val = peer_q;
         SEL_MODE: rd_val = {{(DATA_W-1){1'b0}}, card_q};
         default:  rd_val = '0;
      endcase
   end
endmodule

// File: rtl/cfgp_filter.sv
module cfgp_filter
   import cfgp_pkg::*;
#(
   parameter int BUS_W        = 8,
   parameter int DEV_W        = 5,
   parameter int FN_W         = 2,
   parameter int CARD_MAX_DEV = 1
) (
   input  logic [DATA_W-1:0] addr_q,
   input  logic [BUS_W-1:0]  loc_bus,
   input  logic              card_mode,
   output logic              enabled,
   output logic              allowed,
   output logic [DATA_W-1:0] fmt_addr
);
   logic [BUS_W-1:0] bus;
   logic [DEV_W-1:0] dev;
   logic [FN_W-1:0]  fn;
   logic             on_local;
   logic             blk_dev0;
   logic             blk_card;

   assign bus      = addr_q[BUS_LSB +: BUS_W];
   assign dev      = addr_q[DEV_LSB +: DEV_W];
   assign fn       = addr_q[FN_LSB +: FN_W];
   assign enabled  = addr_q[EN_BIT];
   assign on_local = (bus == loc_bus);
   assign blk_dev0 = on_local && (dev == '0) && (fn != '0);

   if (CARD_MAX_DEV >= 0) begin : g_card
      assign blk_card = on_local && card_mode && (int'(dev) > CARD_MAX_DEV);
   end else begin : g_nocard
      assign blk_card = 1'b0;
   end

   assign allowed = !blk_dev0 && !blk_card;

   always_comb begin
      fmt_addr         = addr_q;
      fmt_addr[EN_BIT] = 1'b0;
   end
endmodule

// File: rtl/cfgp_lane.sv
module cfgp_lane
   import cfgp_pkg::*;
#(
   parameter int LANES  = DATA_W / 8,
   parameter int OFF_W  = $clog2(LANES),
   parameter int SIZE_W = $clog2(LANES) + 1
) (
   input  logic [OFF_W-1:0]  off,
   input  logic [SIZE_W-1:0] size,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [DATA_W-1:0] rdata_in,
   output logic              size_ok,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wdata_out,
   output logic [DATA_W-1:0] rdata_out
);
   logic [DATA_W-1:0] wsh;
   logic [DATA_W-1:0] rsh;

   if (LANES * 8 != DATA_W) begin : g_bad_w
      $error("data width must be whole bytes");
   end

   assign size_ok = (size != '0) && ((size & (size - 1'b1)) == '0) && (int'(size) <= LANES);
   assign wsh     = wdata_in << (8 * int'(off));
   assign rsh     = rdata_in >> (8 * int'(off));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic in_win;
      logic keep;
      assign in_win = (i >= int'(off)) && (i < int'(off) + int'(size));
      assign keep   = (i < int'(size));
      assign be[i]  = size_ok && in_win;
      assign wdata_out[8*i +: 8] = be[i] ? wsh[8*i +: 8] : 8'h00;
      assign rdata_out[8*i +: 8] = keep ? rsh[8*i +: 8] : 8'h00;
   end
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
   import cfgp_pkg::*;
#(
   parameter int BUS_W        = 8,
   parameter int DEV_W        = 5,
   parameter int FN_W         = 2,
   parameter int REG_W        = 6,
   parameter int CARD_MAX_DEV = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hb_valid,
   input  logic        hb_write,
   input  logic [1:0]  hb_sel,
   input  logic [1:0]  hb_off,
   input  logic [2:0]  hb_size,
   input  logic [31:0] hb_wdata,
   output logic        hb_rsp_valid,
   output logic [1:0]  hb_rsp_status,
   output logic [31:0] hb_rsp_rdata,
   output logic        busy,
   output logic        cfg_req_valid,
   output logic        cfg_req_write,
   output logic [31:0] cfg_req_addr,
   output logic [3:0]  cfg_req_be,
   output logic [31:0] cfg_req_wdata,
   input  logic        cfg_done,
   input  logic [31:0] cfg_rdata
);
   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] addr_q, peer_q, reg_rd, fmt_addr;
   logic [BUS_W-1:0]  loc_bus_w;
   logic              card_mode_w;
   logic              enabled, allowed;
   logic              acc, acc_data, reg_wr;
   logic              wsize_ok, rsize_ok_unused;
   logic [LANES-1:0]  wbe, rbe_unused;
   logic [DATA_W-1:0] wdata_al, rdata_unused, wdata_unused, rdata_ext;
   logic [1:0]        pend_off;
   logic [2:0]        pend_size;
   logic              pend_write;

   assign acc      = hb_valid && !busy;
   assign acc_data = acc && (hb_sel == SEL_DATA);
   assign reg_wr   = acc && hb_write && (hb_sel != SEL_DATA);

   cfgp_regs #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(hb_sel), .wdata(hb_wdata),
      .addr_q(addr_q), .peer_q(peer_q), .card_q(card_mode_w), .rd_val(reg_rd)
   );

   assign loc_bus_w = peer_q[BUS_LSB +: BUS_W];

   cfgp_filter #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .CARD_MAX_DEV(CARD_MAX_DEV)) u_filt (
      .addr_q(addr_q), .loc_bus(loc_bus_w), .card_mode(card_mode_w),
      .enabled(enabled), .allowed(allowed), .fmt_addr(fmt_addr)
   );

   cfgp_lane u_wlane (
      .off(hb_off), .size(hb_size), .wdata_in(hb_wdata), .rdata_in('0),
      .size_ok(wsize_ok), .be(wbe), .wdata_out(wdata_al), .rdata_out(rdata_unused)
   );

   cfgp_lane u_rlane (
      .off(pend_off), .size(pend_size), .wdata_in('0), .rdata_in(cfg_rdata),
      .size_ok(rsize_ok_unused), .be(rbe_unused), .wdata_out(wdata_unused), .rdata_out(rdata_ext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy          <= 1'b0;
         hb_rsp_valid  <= 1'b0;
         hb_rsp_status <= ST_OK;
         hb_rsp_rdata  <= '0;
         cfg_req_valid <= 1'b0;
         cfg_req_write <= 1'b0;
         cfg_req_addr  <= '0;
         cfg_req_be    <= '0;
         cfg_req_wdata <= '0;
         pend_off      <= '0;
         pend_size     <= '0;
         pend_write    <= 1'b0;
      end else begin
         hb_rsp_valid  <= 1'b0;
         cfg_req_valid <= 1'b0;
         if (busy) begin
            if (cfg_done) begin
               busy          <= 1'b0;
               hb_rsp_valid  <= 1'b1;
               hb_rsp_status <= ST_OK;
               hb_rsp_rdata  <= pend_write ? '0 : rdata_ext;
            end
         end else if (acc_data) begin
            if (!wsize_ok) begin
               hb_rsp_valid  <= 1'b1;
               hb_rsp_status <= ST_BAD_SIZE;
               hb_rsp_rdata  <= '1;
            end else if (!enabled || !allowed) begin
               hb_rsp_valid  <= 1'b1;
               hb_rsp_status <= ST_NOT_FOUND;
               hb_rsp_rdata  <= '1;
            end else begin
               busy          <= 1'b1;
               cfg_req_valid <= 1'b1;
               cfg_req_write <= hb_write;
               cfg_req_addr  <= fmt_addr;
               cfg_req_be    <= hb_write ? wbe : '1;
               cfg_req_wdata <= hb_write ? wdata_al : '0;
               pend_off      <= hb_off;
               pend_size     <= hb_size;
               pend_write    <= hb_write;
            end
         end else if (acc) begin
            hb_rsp_valid  <= 1'b1;
            hb_rsp_status <= ST_OK;
            hb_rsp_rdata  <= hb_write ? '0 : reg_rd;
         end
      end
   end
endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        hb_valid,
   input logic [1:0]  hb_sel,
   input logic        hb_rsp_valid,
   input logic [1:0]  hb_rsp_status,
   input logic [31:0] hb_rsp_rdata,
   input logic        busy,
   input logic        cfg_req_valid,
   input logic        cfg_req_write,
   input logic [31:0] cfg_req_addr,
   input logic [3:0]  cfg_req_be,
   input logic        cfg_done,
   input logic [7:0]  loc_bus_w,
   input logic        card_mode_w
);
   AST_REQ_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid |-> busy); // R2
   AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid |=> !cfg_req_valid); // R2
   AST_REQ_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_req_valid) |-> $past(hb_valid && hb_sel == 2'd1)); // R2
   AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid && !cfg_req_write |-> cfg_req_be == 4'hF); // R4
   AST_WRITE_SOME_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid && cfg_req_write |-> cfg_req_be != 4'h0); // R4
   AST_NO_LOCAL_DEV0_FN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid && cfg_req_addr[23:16] == loc_bus_w && cfg_req_addr[15:11] == 5'd0
      |-> cfg_req_addr[9:8] == 2'd0); // R5
   AST_CARD_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid && card_mode_w && cfg_req_addr[23:16] == loc_bus_w
      |-> cfg_req_addr[15:11] <= 5'd1); // R6
   AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      hb_rsp_valid && hb_rsp_status != 2'd0 |-> hb_rsp_rdata == 32'hFFFF_FFFF); // R7
   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cfg_done |=> !busy && hb_rsp_valid && hb_rsp_status == 2'd0); // R9
   AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !cfg_done |=> !hb_rsp_valid); // R9
endmodule

bind cfgp_port cfgp_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .hb_valid(hb_valid), .hb_sel(hb_sel),
   .hb_rsp_valid(hb_rsp_valid), .hb_rsp_status(hb_rsp_status), .hb_rsp_rdata(hb_rsp_rdata),
   .busy(busy), .cfg_req_valid(cfg_req_valid), .cfg_req_write(cfg_req_write),
   .cfg_req_addr(cfg_req_addr), .cfg_req_be(cfg_req_be), .cfg_done(cfg_done),
   .loc_bus_w(loc_bus_w), .card_mode_w(card_mode_w)
);

// File: tb/tb_cfgp_port.sv
module tb_cfgp_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hb_valid = 1'b0, hb_write = 1'b0;
   logic [1:0]  hb_sel = '0, hb_off = '0;
   logic [2:0]  hb_size = 3'd4;
   logic [31:0] hb_wdata = '0;
   logic        hb_rsp_valid;
   logic [1:0]  hb_rsp_status;
   logic [31:0] hb_rsp_rdata;
   logic        busy, cfg_req_valid, cfg_req_write;
   logic [31:0] cfg_req_addr, cfg_req_wdata;
   logic [3:0]  cfg_req_be;
   logic        cfg_done = 1'b0;
   logic [31:0] cfg_rdata = '0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [31:0] m_addr = '0;
   logic [7:0]  m_lbus = '0;
   logic        m_card = 1'b0;

   always #4 clk = ~clk;

   cfgp_port dut (.*);

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic blocked(input logic [31:0] a);
      logic [7:0] b = a[23:16];
      logic [4:0] d = a[15:11];
      logic [1:0] f = a[9:8];
      return (b == m_lbus) && ((d == 0 && f != 0) || (m_card && d > 1));
   endfunction

   function automatic logic [3:0] exp_be(input logic [1:0] off, input logic [2:0] sz);
      logic [7:0] m = (sz == 1) ? 8'h1 : (sz == 2) ? 8'h3 : 8'hF;
      return 4'((m << off));
   endfunction

   function automatic logic [31:0] exp_rd(input logic [31:0] raw, input logic [1:0] off, input logic [2:0] sz);
      logic [31:0] s = raw >> (8 * off);
      return (sz == 1) ? (s & 32'hFF) : (sz == 2) ? (s & 32'hFFFF) : s;
   endfunction

   // one register-bus request; returns at the negedge after the sampling edge
   task automatic req(input logic w, input logic [1:0] sel, input logic [1:0] off,
                      input logic [2:0] sz, input logic [31:0] d);
      hb_valid = 1'b1; hb_write = w; hb_sel = sel; hb_off = off; hb_size = sz; hb_wdata = d;
      @(negedge clk);
      hb_valid = 1'b0;
   endtask

   task automatic reg_acc(input logic w, input logic [1:0] sel, input logic [31:0] d,
                          input logic [31:0] exp, input string tag);
      req(w, sel, 2'd0, 3'd4, d);
      chk(hb_rsp_valid && hb_rsp_status == 2'd0 && !cfg_req_valid, tag, {30'd0, hb_rsp_status}, 32'd0);
      chk(hb_rsp_rdata == exp, tag, hb_rsp_rdata, exp);
   endtask

   task automatic set_addr(input logic [31:0] a);
      req(1'b1, 2'd0, 2'd0, 3'd4, a);
      m_addr = a & 32'h80FF_FBFC;
   endtask

   task automatic data_acc(input logic w, input logic [1:0] off, input logic [2:0] sz,
                           input logic [31:0] d, input logic [31:0] raw, input int lat);
      logic sz_ok = (sz == 1 || sz == 2 || sz == 4);
      logic [31:0] ea = {8'h00, m_addr[23:11], 1'b0, m_addr[9:2], 2'b00};
      req(w, 2'd1, off, sz, d);
      if (!sz_ok) begin
         chk(hb_rsp_valid && hb_rsp_status == 2'd2 && !cfg_req_valid, "R8 bad size", {30'd0, hb_rsp_status}, 32'd2);
         chk(hb_rsp_rdata == 32'hFFFF_FFFF, "R8 data", hb_rsp_rdata, 32'hFFFF_FFFF);
      end else if (!m_addr[31] || blocked(m_addr)) begin
         chk(hb_rsp_valid && hb_rsp_status == 2'd1 && !cfg_req_valid && !busy,
             "R7 R5 R6 blocked", {30'd0, hb_rsp_status}, 32'd1);
         chk(hb_rsp_rdata == 32'hFFFF_FFFF, "R7 ones", hb_rsp_rdata, 32'hFFFF_FFFF);
      end else begin
         chk(cfg_req_valid && busy && !hb_rsp_valid, "R2 issue", {31'd0, cfg_req_valid}, 32'd1);
         chk(cfg_req_addr == ea && cfg_req_write == w, "R2 addr", cfg_req_addr, ea);
         if (w) begin
            chk(cfg_req_be == exp_be(off, sz), "R4 be", {28'd0, cfg_req_be}, {28'd0, exp_be(off, sz)});
            for (int i = 0; i < 4; i++)
               if (cfg_req_be[i])
                  chk(cfg_req_wdata[8*i +: 8] == 8'((d << (8 * off)) >> (8 * i)), "R4 wdata",
                      cfg_req_wdata, d << (8 * off));
         end else
            chk(cfg_req_be == 4'hF, "R4 read be", {28'd0, cfg_req_be}, 32'hF);
         for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(busy && !cfg_req_valid && !hb_rsp_valid, "R9 hold", {31'd0, busy}, 32'd1);
         end
         cfg_done = 1'b1; cfg_rdata = raw;
         @(negedge clk);
         cfg_done = 1'b0;
         chk(hb_rsp_valid && hb_rsp_status == 2'd0 && !busy, "R9 complete", {30'd0, hb_rsp_status}, 32'd0);
         chk(hb_rsp_rdata == (w ? 32'd0 : exp_rd(raw, off, sz)), "R3 read data",
             hb_rsp_rdata, w ? 32'd0 : exp_rd(raw, off, sz));
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      chk(!busy && !hb_rsp_valid && !cfg_req_valid, "R10 reset outputs", {31'd0, busy}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      reg_acc(1'b0, 2'd0, 0, 32'd0, "R10 addr reset");
      reg_acc(1'b0, 2'd2, 0, 32'd0, "R10 peer reset");
      reg_acc(1'b0, 2'd3, 0, 32'd0, "R10 mode reset");
      // R1 field masking
      reg_acc(1'b1, 2'd0, 32'hFFFF_FFFF, 32'd0, "R11 write ack");
      reg_acc(1'b0, 2'd0, 0, 32'h80FF_FBFC, "R1 readback");
      reg_acc(1'b1, 2'd2, 32'hFFFF_FFFF, 32'd0, "R11 write ack");
      reg_acc(1'b0, 2'd2, 0, 32'h1FFF_0000, "R5 peer readback");
      reg_acc(1'b1, 2'd2, 32'h0305_0000, 32'd0, "R5 set local");
      m_lbus = 8'h05;
      reg_acc(1'b1, 2'd3, 32'hFFFF_FFFF, 32'd0, "R6 mode");
      reg_acc(1'b0, 2'd3, 0, 32'd1, "R6 mode readback");
      m_card = 1'b1;
      // directed corners
      set_addr(32'h8005_0100);            // local, dev0 fn1
      data_acc(1'b0, 0, 4, 0, 0, 0);      // R5 blocked
      set_addr(32'h8005_1000);            // local dev2, card mode
      data_acc(1'b0, 0, 4, 0, 0, 0);      // R6 blocked
      set_addr(32'h8007_1000);            // other bus dev2
      data_acc(1'b0, 0, 4, 0, 32'hA1B2_C3D4, 1);   // R6 not affected
      set_addr(32'h0007_0808);            // enable clear
      data_acc(1'b0, 0, 4, 0, 0, 0);      // R7
      set_addr(32'h8005_0804);            // local dev1
      data_acc(1'b0, 1, 3, 0, 0, 0);      // R8 size 3
      data_acc(1'b0, 3, 2, 0, 32'hDEAD_BEEF, 2);   // R3 halfword at 3
      data_acc(1'b1, 3, 2, 32'h0000_5A6B, 0, 0);   // R4 one lane
      // R9: address write while busy is dropped
      req(1'b0, 2'd1, 0, 4, 0);
      chk(cfg_req_valid, "R9 issue", {31'd0, cfg_req_valid}, 1);
      req(1'b1, 2'd0, 0, 4, 32'h8009_0000);
      chk(!hb_rsp_valid && busy, "R9 dropped", {31'd0, hb_rsp_valid}, 0);
      cfg_done = 1'b1;
      @(negedge clk);
      cfg_done = 1'b0;
      chk(hb_rsp_valid && !busy, "R9 done", {31'd0, hb_rsp_valid}, 1);
      reg_acc(1'b0, 2'd0, 0, 32'h8005_0804, "R9 addr unchanged");
      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [31:0] a;
         logic [2:0]  sz;
         int          r = $urandom_range(0, 9);
         a = $urandom;
         a[31] = ($urandom_range(0, 7) != 0);
         if ($urandom_range(0, 1)) a[23:16] = m_lbus;
         if ($urandom_range(0, 1)) a[15:11] = 5'($urandom_range(0, 3));
         if (n % 50 == 0) begin
            m_card = ~m_card;
            req(1'b1, 2'd3, 0, 4, {31'd0, m_card});
         end
         set_addr(a);
         sz = (r == 0) ? 3'($urandom_range(0, 7)) : (r < 4) ? 3'd1 : (r < 7) ? 3'd2 : 3'd4;
         data_acc(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), sz, $urandom, $urandom,
                  $urandom_range(0, 3));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule